// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is a mode-0 SPI slave that behaves like a small byte-addressed nonvolatile memory. A host lowers the active-low select, shifts an 8-bit command in MSB first and, for memory commands, a 24-bit address. For a write command it then shifts in one data byte. For a read command the slave returns one data byte. The slave also supports a write-enable command, a status read and a low-power sleep command. The slave stores its bytes in an internal array and keeps a status register whose bit 1 is the write-enable latch.

All inputs are sampled in the system clock domain. The serial clock edges are detected by comparing each sample with the one before it, so every SCK phase must last at least two system clock cycles. The array depth is set by `MEM_AW`, which gives the number of address bits decoded. The default of 10 makes 1024 bytes. A value of 13 gives the full 8 KiB device.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset every memory byte reads 0xFF, the status register reads 0x00, `miso` is low and `asleep` is low.
- R2: A frame starts on the falling edge of `cs_n`. Bits are sampled on SCK rising edges and the first eight form the command, MSB first. The bit count restarts whenever `cs_n` is high, so a frame with fewer than eight bits has no effect.
- R3: Command 0x03 followed by three address bytes returns the addressed byte on `miso`, MSB first. The first data bit is valid after the SCK falling edge that follows the 32nd rising edge.
- R4: Only the low `MEM_AW` bits of the 24-bit address select a byte. The upper bits are ignored, so addresses that differ only above bit `MEM_AW`-1 refer to the same byte.
- R5: Command 0x02 followed by three address bytes stores the next eight bits at the addressed byte, provided the write-enable latch is set. No other byte changes, and bits after that first data byte are ignored.
- R6: Command 0x06 sets the write-enable latch (status bit 1) on the rising edge of `cs_n` that closes a frame holding at least the full command byte.
- R7: Command 0x05 returns the status byte on `miso`, MSB first, starting right after the command byte. Bit 1 is the write-enable latch and every other bit reads 0.
- R8: A write frame with the latch clear leaves memory unchanged. Any frame holding a complete 0x02 command clears the latch when `cs_n` rises.
- R9: Command 0xB9 sets `asleep` on the closing rising edge of `cs_n`. `asleep` clears on the next falling edge of `cs_n`, and the frame opened by that edge is discarded in full.
- R10: While `asleep` is high and during the discarded waking frame, SCK and MOSI have no effect and `miso` stays low.
- R11: `miso` is low whenever `cs_n` is high, and while selected it changes only after an SCK falling edge.
- R12: Any other command byte changes neither memory nor the latch, and `miso` stays low for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; its edges frame each transaction |
| sck | input | 1 | Serial clock, mode 0 (idle low) |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host; low when not selected |
| asleep | output | 1 | High while the slave is in sleep mode |

## Verification
The hardest case to reach is the waking frame. The slave must first be put to sleep with the write-enable latch set. A complete, well-formed write frame then has to be sent as the frame that wakes it. The bench sets up exactly this case. It then reads the target byte and the status, to show that the frame changed neither memory nor the latch. The bench also sweeps every command byte that is not decoded, with the latch held set. It sweeps 64 addresses spread over the array as well, each written through differing upper address bits and then read back together with its neighbour.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int MEM_AW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic asleep
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [5:0] BIT_CMD  = 6'd8;
  localparam logic [5:0] BIT_ADR  = 6'd32;
  localparam logic [5:0] BIT_END  = 6'd40;

  logic       sck_q, cs_q;
  logic [5:0] bcnt;
  logic [6:0] sh;
  logic [7:0] cmd;
  logic [23:0] adr;
  logic [7:0] obuf;
  logic       wel, drop;
  logic [7:0] mem [DEPTH];

  wire sck_rise = ~cs_n & sck & ~sck_q;
  wire sck_fall = ~cs_n & ~sck & sck_q;
  wire cs_fall  = ~cs_n & cs_q;
  wire cs_rise  = cs_n & ~cs_q;
  wire live     = ~asleep & ~drop;
  wire have_cmd = bcnt >= BIT_CMD;
  wire [7:0] din = {sh, mosi};
  wire [MEM_AW-1:0] idx = adr[MEM_AW-1:0];
  wire [7:0] status = {6'b0, wel, 1'b0};

  assign miso = ~cs_n & obuf[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      sh   <= '0;
      cmd  <= '0;
      adr  <= '0;
    end else if (cs_n) begin
      bcnt <= '0;
    end else if (sck_rise && live) begin
      sh <= din[6:0];
      if (bcnt != BIT_END) bcnt <= bcnt + 6'd1;
      if (bcnt == BIT_CMD - 6'd1) cmd <= din;
      else if (bcnt >= BIT_CMD && bcnt < BIT_ADR) adr <= {adr[22:0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (sck_rise && live && bcnt == BIT_END - 6'd1 && cmd == OP_WRITE && wel) begin
      mem[idx] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      asleep <= 1'b0;
      drop   <= 1'b0;
    end else if (cs_fall) begin
      if (asleep) drop <= 1'b1;
      asleep <= 1'b0;
    end else if (cs_rise) begin
      drop <= 1'b0;
      if (live && have_cmd) begin
        case (cmd)
          OP_WREN:  wel <= 1'b1;
          OP_WRITE: wel <= 1'b0;
          OP_SLEEP: asleep <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0;
    end else if (cs_n) begin
      obuf <= '0;
    end else if (sck_fall && live) begin
      if (bcnt == BIT_CMD && cmd == OP_RDSR) obuf <= status;
      else if (bcnt == BIT_ADR && cmd == OP_READ) obuf <= mem[idx];
      else obuf <= {obuf[6:0], 1'b0};
    end
  end
endmodule

module spi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic miso,
  input logic asleep,
  input logic wel
);
  a_r6_wel_sets_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> cs_n);
  a_r8_wel_clears_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> cs_n);
  a_r9_sleep_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> cs_n);
  a_r9_wake_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !cs_n);
  a_r10_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !miso);
  a_r11_miso_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(miso)) |-> !sck);
endmodule

bind spi_mem_slave spi_mem_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
  .miso(miso), .asleep(asleep), .wel(wel)
);

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;
  localparam int AW = 10;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso, asleep;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] exp_mem [1 << AW];
  logic exp_wel = 1'b0;

  always #10 clk = ~clk;

  spi_mem_slave #(.MEM_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .asleep(asleep)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b; sck = 1'b0; tick(HALF);
    r = miso; sck = 1'b1; tick(HALF);
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
    for (int k = 7; k >= 0; k--) xbit(d[k], q[k]);
  endtask

  task automatic begin_f();
    cs_n = 1'b0; tick(3);
  endtask

  task automatic end_f();
    sck = 1'b0; tick(HALF); cs_n = 1'b1; tick(4);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] q;
    xbyte(a[23:16], q); xbyte(a[15:8], q); xbyte(a[7:0], q);
  endtask

  task automatic cmd_only(input logic [7:0] op);
    logic [7:0] q;
    begin_f(); xbyte(op, q); end_f();
  endtask

  task automatic wren();
    cmd_only(8'h06); exp_wel = 1'b1;
  endtask

  task automatic rd(input logic [23:0] a, output logic [7:0] d);
    logic [7:0] q;
    begin_f(); xbyte(8'h03, q); send_addr(a); xbyte(8'h00, d); end_f();
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    logic [7:0] q;
    begin_f(); xbyte(8'h02, q); send_addr(a); xbyte(d, q); end_f();
    if (exp_wel) exp_mem[a[AW-1:0]] = d;
    exp_wel = 1'b0;
  endtask

  task automatic chk_status(input string req);
    logic [7:0] q, s;
    begin_f(); xbyte(8'h05, q); xbyte(8'h00, s); end_f();
    chk(req, s, {6'b0, exp_wel, 1'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, q;
    logic r;
    logic [AW-1:0] a;
    for (int i = 0; i < (1 << AW); i++) exp_mem[i] = 8'hFF;
    tick(4); rst_n = 1'b1; tick(4);

    chk("R1 miso", miso, 0);
    chk("R1 asleep", asleep, 0);
    chk_status("R1 status");
    rd(24'h000000, d); chk("R1 mem lo", d, 8'hFF);
    rd(24'h0003FF, d); chk("R1 mem hi", d, 8'hFF);

    wr(24'h000005, 8'h12);
    rd(24'h000005, d); chk("R8 no write without latch", d, 8'hFF);

    begin_f(); for (int k = 7; k >= 1; k--) xbit(k == 2 || k == 1, r); end_f();
    chk_status("R2 partial command ignored");
    begin_f(); xbyte(8'h06, q); chk("R11 quiet during command", q, 0); end_f();
    exp_wel = 1'b1;
    chk("R11 miso low deselected", miso, 0);
    chk_status("R6 R7 latch set");

    for (int i = 0; i < 64; i++) begin
      a = AW'(i * 16 + (i % 16));
      d = 8'(i * 29 + 3) ^ 8'h80;
      wren();
      wr({14'(i * 977 + 1), a}, d);
      rd({14'(i * 31 + 5), a}, q);
      chk("R3 R4 readback", q, exp_mem[a]);
      rd({14'd0, AW'(a + 1)}, q);
      chk("R5 neighbour kept", q, exp_mem[AW'(a + 1)]);
      if (i % 8 == 0) chk_status("R8 latch cleared by write");
    end

    wren();
    begin_f(); xbyte(8'h02, q); send_addr(24'h000300); xbyte(8'h3C, q); xbyte(8'hC3, q); end_f();
    exp_mem[10'h300] = 8'h3C; exp_wel = 1'b0;
    rd(24'h000300, d); chk("R5 first byte kept", d, 8'h3C);
    rd(24'h000301, d); chk("R5 extra bits ignored", d, exp_mem[10'h301]);

    wren();
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h02 || op == 8'h03 || op == 8'h05 || op == 8'h06 || op == 8'hB9) continue;
      begin_f(); xbyte(8'(op), q); send_addr(24'hFFFFFF); xbyte(8'hFF, q); end_f();
      chk("R12 no output", q, 0);
      chk_status("R12 latch unchanged");
    end
    rd(24'hFFFFFF, d); chk("R12 memory unchanged", d, exp_mem[10'h3FF]);

    begin_f(); for (int k = 7; k >= 1; k--) xbit(k == 7 || k == 5 || k == 4 || k == 3, r); end_f();
    chk("R2 partial sleep ignored", asleep, 0);
    cmd_only(8'hB9);
    chk("R9 asleep set", asleep, 1);
    for (int k = 0; k < 4; k++) begin
      sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    chk("R10 miso low asleep", miso, 0);
    begin_f();
    chk("R9 wake on select", asleep, 0);
    xbyte(8'h02, q); send_addr(24'h000007); xbyte(8'h00, q);
    chk("R10 waking frame silent", q, 0);
    end_f();
    rd(24'h000007, d); chk("R10 waking write dropped", d, exp_mem[7]);
    chk_status("R10 latch kept through waking frame");
    wr(24'h000007, 8'hA6);
    rd(24'h000007, d); chk("R9 normal after wake", d, 8'hA6);
    chk_status("R8 latch cleared after wake");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule